// File: doc/BRIEF.md
# Page-Write Load Window Controller

This block sits behind a parallel, memory-style strobe interface and groups byte writes into a page before programming them. Each byte write carries an 11-bit address and an 8-bit value. The block places every byte in a page buffer and restarts a load-window timer. When the timer runs out with no new byte, the block goes busy for a fixed programming time. It then copies all buffered bytes into a byte-wide array model in a single step and returns to idle.

A read on the same strobes returns array contents while the block is idle. While a page is loading or programming, a read returns a status byte instead. In that byte, bit 5 shows whether the load timer is still running (0) or has expired (1). The strobes are level inputs that the block samples on its own clock. There is no valid/ready handshake and no back-pressure. A byte that arrives while busy is high is simply not taken, so the host must wait for busy to fall.

Top module: `page_load_ctrl`

## Requirements
- R1: A byte write is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1 at the same time. Strobe activity with `oe_n`=0, or with only one of `ce_n`/`we_n` low, writes nothing and starts no load.
- R2: The address is taken in the first cycle where both `ce_n` and `we_n` are low, that is, when the later of the two falls. The data is the value on `din` in the last cycle before either strobe rises.
- R3: All bytes loaded into one page are committed together by a single programming cycle. A page is up to 64 bytes that share address bits [10:6], with address bits [5:0] as the offset. Addresses outside that page are untouched.
- R4: Programming starts WIN_CYC cycles after the last accepted byte is taken. Each accepted byte restarts the window, so bytes spaced closer than the window extend the load.
- R5: A read (`ce_n`=0, `oe_n`=0, `we_n`=1) returns 8'h00 while loading and 8'h20 (bit 5 set) while busy. In idle it returns the array byte at `addr`. `dout` is 0 when no read is active.
- R6: `busy` stays high for exactly PROG_CYC cycles. The array shows the new page contents only once `busy` has fallen.
- R7: During a load, a byte whose bits [10:6] differ from those of the first byte of the page is dropped. It also sets `page_err`, which stays high until reset.
- R8: Write strobes while `busy` is high are ignored. They change no array byte and start no new load.
- R9: After reset, `busy` and `page_err` are low and every array byte reads 8'hFF.
- R10: Writing the same page offset twice in one load keeps the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Byte address; bits [10:6] select the page |
| din | input | 8 | Write data |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| dout | output | 8 | Read data or status byte |
| busy | output | 1 | High while the page is being programmed |
| page_err | output | 1 | Sticky flag for a dropped out-of-page byte |

## Verification
The hardest case to reach is a byte write whose strobes are active only while `busy` is high. It depends on the exact cycle where the load window expires. The bench measures that cycle, issues the write inside the programming interval and then confirms that nothing happened. It also checks the split address/data capture by staggering `we_n` and `ce_n` and changing `addr` and `din` between the two strobe edges. Restart of the window is reached by spacing bytes just under the window length and timing the final busy rise from the last byte.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pld_state_e;
endpackage

// File: rtl/pld_strobe.sv
// Turns sampled strobes into one-cycle byte events with captured address/data.
module pld_strobe #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              busy,
  output logic              evt,
  output logic [ADDR_W-1:0] ev_addr,
  output logic [DATA_W-1:0] ev_data
);
  logic              wr_act, wr_q;
  logic [ADDR_W-1:0] addr_lat;
  logic [DATA_W-1:0] din_q;

  assign wr_act = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      addr_lat <= '0;
      din_q    <= '0;
      evt      <= 1'b0;
      ev_addr  <= '0;
      ev_data  <= '0;
    end else begin
      wr_q  <= wr_act;
      din_q <= din;
      if (wr_act && !wr_q) addr_lat <= addr;   // later-falling strobe
      evt <= wr_q && !wr_act && !busy;         // earlier-rising strobe
      if (wr_q && !wr_act) begin
        ev_addr <= addr_lat;
        ev_data <= din_q;
      end
    end
  end
endmodule

// File: rtl/pld_seq.sv
// Load window / programming sequencer.
module pld_seq
  import pld_pkg::*;
#(
  parameter int TAG_W    = 5,
  parameter int WIN_CYC  = 16,
  parameter int PROG_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [TAG_W-1:0] ev_tag,
  output pld_state_e       st,
  output logic [TAG_W-1:0] tag,
  output logic             accept,
  output logic             commit,
  output logic             page_err
);
  localparam int WIN_W  = (WIN_CYC  > 1) ? $clog2(WIN_CYC)  : 1;
  localparam int PROG_W = (PROG_CYC > 1) ? $clog2(PROG_CYC) : 1;

  pld_state_e        st_q;
  logic [WIN_W-1:0]  win_q;
  logic [PROG_W-1:0] prog_q;
  logic              tag_ok;

  assign st     = st_q;
  assign tag_ok = (st_q == ST_IDLE) || (ev_tag == tag);
  assign accept = evt && (st_q != ST_PROG) && tag_ok;
  assign commit = (st_q == ST_PROG) && (prog_q == PROG_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      win_q    <= '0;
      prog_q   <= '0;
      tag      <= '0;
      page_err <= 1'b0;
    end else begin
      if (evt && (st_q == ST_LOAD) && !tag_ok) page_err <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_LOAD;
          tag   <= ev_tag;
          win_q <= '0;
        end
        ST_LOAD: begin
          if (accept) win_q <= '0;
          else if (win_q == WIN_W'(WIN_CYC - 1)) begin
            st_q   <= ST_PROG;
            prog_q <= '0;
          end else win_q <= win_q + 1'b1;
        end
        ST_PROG: begin
          if (commit) st_q <= ST_IDLE;
          else prog_q <= prog_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pld_store.sv
// Page buffer plus array model; commit copies valid slots in one cycle.
module pld_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [PAGE_W-1:0]        ev_off,
  input  logic [DATA_W-1:0]        ev_data,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] tag,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [DATA_W-1:0]        rdata
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int MEM_N  = 1 << ADDR_W;

  logic [DATA_W-1:0] pg_data [PAGE_N];
  logic [PAGE_N-1:0] pg_vld;
  logic [DATA_W-1:0] mem_q   [MEM_N];

  for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pg_data[g] <= '0;
        pg_vld[g]  <= 1'b0;
      end else if (commit) begin
        pg_vld[g] <= 1'b0;
      end else if (accept && (ev_off == PAGE_W'(g))) begin
        pg_data[g] <= ev_data;
        pg_vld[g]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem_q[i] <= '1;
    end else if (commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (pg_vld[i]) mem_q[{tag, PAGE_W'(i)}] <= pg_data[i];
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pld_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 6,
  parameter int WIN_CYC  = 16,
  parameter int PROG_CYC = 40,
  parameter int STAT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic              page_err
);
  localparam int TAG_W = ADDR_W - PAGE_W;

  pld_state_e        st;
  logic              evt, accept, commit, rd_act;
  logic [ADDR_W-1:0] ev_addr;
  logic [DATA_W-1:0] ev_data, rdata, status;
  logic [TAG_W-1:0]  tag;

  assign busy = (st == ST_PROG);

  pld_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) strobe_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy),
    .evt(evt), .ev_addr(ev_addr), .ev_data(ev_data)
  );

  pld_seq #(.TAG_W(TAG_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ev_tag(ev_addr[ADDR_W-1:PAGE_W]),
    .st(st), .tag(tag), .accept(accept), .commit(commit), .page_err(page_err)
  );

  pld_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) store_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .ev_off(ev_addr[PAGE_W-1:0]),
    .ev_data(ev_data), .commit(commit), .tag(tag), .raddr(addr), .rdata(rdata)
  );

  assign rd_act = !ce_n && !oe_n && we_n;
  assign status = (st == ST_PROG) ? (DATA_W'(1) << STAT_BIT) : '0;

  always_comb begin
    if (!rd_act)            dout = '0;
    else if (st == ST_IDLE) dout = rdata;
    else                    dout = status;
  end
endmodule

// File: rtl/pld_chk.sv
module pld_chk
  import pld_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PROG_CYC = 40,
  parameter int STAT_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] dout,
  input logic              busy,
  input logic              page_err,
  input pld_state_e        st
);
  localparam int RUN_W = $clog2(PROG_CYC + 2) + 1;
  logic [RUN_W-1:0] busy_run;
  logic             rd_act;

  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_busy_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < RUN_W'(PROG_CYC)));
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == RUN_W'(PROG_CYC)));
  assert_stat_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && busy) |-> (dout == (DATA_W'(1) << STAT_BIT)));
  assert_stat_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && st == ST_LOAD) |-> (dout == '0));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  assert_prog_from_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(st) == ST_LOAD));
endmodule

bind page_load_ctrl pld_chk #(
  .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .STAT_BIT(STAT_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout(dout), .busy(busy), .page_err(page_err), .st(st)
);

// File: tb/page_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_load_ctrl_tb_top;
  localparam int WIN  = 16;
  localparam int PROG = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [7:0]  dout;
  logic        busy, page_err;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  page_load_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .dout(dout), .busy(busy), .page_err(page_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1 d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // call right after the releasing negedge of the last byte
  task automatic finish_page(output int to_busy, output int len);
    to_busy = 0; len = 0;
    while (!busy) begin @(negedge clk); to_busy++; end
    while (busy)  begin @(negedge clk); len++; end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R9", "busy after reset", busy, 0);
    chk("R9", "page_err after reset", page_err, 0);
    rd(11'h000, d); chk("R9", "erased byte 0x000", d, 8'hFF);
    rd(11'h7FF, d); chk("R9", "erased byte 0x7FF", d, 8'hFF);
  endtask

  task automatic t_gate_r1;
    logic [7:0] d; int seen = 0;
    @(negedge clk); addr = 11'h210; din = 8'h5A; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); addr = 11'h211; din = 8'h6B; ce_n = 1'b1; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    repeat (WIN + 10) begin @(negedge clk); if (busy) seen++; end
    chk("R1", "busy cycles after gated strobes", seen, 0);
    rd(11'h210, d); chk("R1", "byte with oe_n low", d, 8'hFF);
    rd(11'h211, d); chk("R1", "byte with ce_n high", d, 8'hFF);
  endtask

  task automatic t_edges_r2;
    logic [7:0] d; int tb, ln;
    @(negedge clk); addr = 11'h1C0; din = 8'h11; oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk); addr = 11'h1C5; ce_n = 1'b0;
    @(negedge clk); addr = 11'h1C9; din = 8'h3C;
    @(negedge clk); ce_n = 1'b1; din = 8'h77;
    @(negedge clk); we_n = 1'b1;
    finish_page(tb, ln);
    rd(11'h1C5, d); chk("R2", "byte at later-falling address", d, 8'h3C);
    rd(11'h1C0, d); chk("R2", "early address untouched", d, 8'hFF);
    rd(11'h1C9, d); chk("R2", "late address untouched", d, 8'hFF);
  endtask

  task automatic t_full_r3;
    logic [7:0] d; int tb, ln, bad = 0;
    for (int i = 0; i < 64; i++) wr_byte(11'h240 + 11'(i), 8'(i) ^ 8'hA5);
    finish_page(tb, ln);
    chk("R3", "one program cycle for 64 bytes", ln, PROG);
    for (int i = 0; i < 64; i++) begin
      rd(11'h240 + 11'(i), d);
      if (d != (8'(i) ^ 8'hA5)) bad++;
    end
    chk("R3", "mismatching bytes in full page", bad, 0);
    rd(11'h280, d); chk("R3", "next page untouched", d, 8'hFF);
  endtask

  task automatic t_window_r4_r6;
    logic [7:0] d; int tb, ln, seen = 0;
    wr_byte(11'h0C1, 8'hC1);
    repeat (10) begin @(negedge clk); if (busy) seen++; end
    wr_byte(11'h0C2, 8'hC2);
    chk("R4", "busy before window restart", seen, 0);
    finish_page(tb, ln);
    chk("R4", "cycles from last byte to busy", tb, WIN + 2);
    chk("R6", "busy length", ln, PROG);
    rd(11'h0C1, d); chk("R6", "first byte committed", d, 8'hC1);
    rd(11'h0C2, d); chk("R6", "second byte committed", d, 8'hC2);
  endtask

  task automatic t_status_r5;
    logic [7:0] d; int tb, ln;
    wr_byte(11'h105, 8'h9E);
    @(negedge clk); @(negedge clk);
    rd(11'h105, d); chk("R5", "status while loading", d, 8'h00);
    while (!busy) @(negedge clk);
    rd(11'h105, d); chk("R5", "status while busy", d, 8'h20);
    finish_page(tb, ln);
    rd(11'h105, d); chk("R5", "array read in idle", d, 8'h9E);
    #1 chk("R5", "dout with no read", dout, 8'h00);
  endtask

  task automatic t_page_r7;
    logic [7:0] d; int tb, ln;
    wr_byte(11'h300, 8'h42);
    wr_byte(11'h345, 8'h99);
    finish_page(tb, ln);
    chk("R7", "page_err after foreign byte", page_err, 1);
    rd(11'h300, d); chk("R7", "in-page byte kept", d, 8'h42);
    rd(11'h345, d); chk("R7", "foreign byte dropped", d, 8'hFF);
    wr_byte(11'h600, 8'h01);
    finish_page(tb, ln);
    chk("R7", "page_err stays set", page_err, 1);
  endtask

  task automatic t_busy_r8;
    logic [7:0] d; int tb, seen = 0;
    wr_byte(11'h400, 8'h10);
    while (!busy) @(negedge clk);
    wr_byte(11'h401, 8'h20);
    while (busy) @(negedge clk);
    repeat (WIN + 5) begin @(negedge clk); if (busy) seen++; end
    chk("R8", "no load from byte during busy", seen, 0);
    rd(11'h401, d); chk("R8", "byte during busy ignored", d, 8'hFF);
    rd(11'h400, d); chk("R8", "earlier byte committed", d, 8'h10);
  endtask

  task automatic t_overwrite_r10;
    logic [7:0] d; int tb, ln;
    wr_byte(11'h500, 8'h01);
    wr_byte(11'h500, 8'h02);
    finish_page(tb, ln);
    rd(11'h500, d); chk("R10", "last write to same offset", d, 8'h02);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate_r1();
    t_edges_r2();
    t_full_r3();
    t_window_r4_r6();
    t_status_r5();
    t_page_r7();
    t_busy_r8();
    t_overwrite_r10();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule